// File: doc/BRIEF.md
# Hex Dump Response Formatter

This block turns the results of bus cycles into the ASCII character stream that a terminal transmitter sends. A command engine upstream hands it one event at a time: a prompt request, a data word together with the address it was read from, or an end-of-command marker carrying the completion status. The formatter expands each event into characters and passes them one per handshake to the transmitter. It holds the current character for as long as the transmitter is busy.

Read results are laid out as a hex dump. The first word of each line is preceded by its own address and a `" : "` separator. Later words on the line are separated by single spaces. When a line is full, the next word opens a new line. Addresses and data are always printed at the full digit count set by their width parameters, with leading zeros and uppercase letters. At the end of each command a status marker is printed. It goes on the data line when exactly one word was shown, and on its own line when two or more were shown. No ASCII rendering of data is done.

Top module: `hexdump_fmt`

## Requirements
- R1: A prompt event (`evt_kind` = 0) emits exactly the three characters `-`, `>`, space.
- R2: A word event (`evt_kind` = 1) that opens a line emits the address digits, then space, colon, space, then the data digits.
- R3: A word event that does not open a line emits a single space followed by the data digits. At most `WORDS_PER_LINE` (default 8) words share one line.
- R4: The word that follows a full line is preceded by CR (0x0D) and LF (0x0A) and then printed with its own address as in R2.
- R5: Addresses use ceil(`ADDR_W`/4) digits and data use ceil(`DATA_W`/4) digits, zero-padded, with digits A to F in uppercase (0x41 to 0x46).
- R6: An end event (`evt_kind` = 2) after no words in the command emits the marker followed by CR LF.
- R7: An end event after exactly one word emits a space, the marker and CR LF, so the marker stays on the data line.
- R8: An end event after two or more words emits CR LF, the marker and CR LF, so the marker stands on its own line.
- R9: The marker is `OK` for status 0, `E` for status 1 or 3 (bus error) and `!` for status 2 (timeout). Each end event starts the next command with an empty line and a word count of zero.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_char` is unchanged. `evt_ready` is low whenever characters are pending.
- R11: After reset `tx_valid` is low and `evt_ready` is high. Every emitted character is printable ASCII, CR or LF.
- R12: An event with `evt_kind` = 3 is accepted, emits nothing and leaves the line position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Formatter idle and able to take an event |
| evt_kind | input | 2 | 0 prompt, 1 word, 2 end of command, 3 no-op |
| evt_status | input | 2 | Completion status for end events: 0 ok, 1 error, 2 timeout, 3 error |
| evt_addr | input | ADDR_W | Address of the word (word events) |
| evt_data | input | DATA_W | Data word (word events) |
| tx_valid | output | 1 | Character available |
| tx_ready | input | 1 | Transmitter takes the character |
| tx_char | output | 8 | ASCII character |

## Verification
The hardest situation to reach is the line break. It takes a command that has already put exactly `WORDS_PER_LINE` words on a line, with the next word arriving before the end event. The stimulus gets there with a ten-word read, so the break falls inside the command rather than at its end. The same command is then followed by a single-word read, which shows that the line position and word count were cleared by the end event. Transmitter back-pressure is applied both as a pseudo-random ready pattern and as a long forced stall in the middle of a prompt. This checks that characters are held and never skipped or repeated.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

   typedef enum logic [1:0] {
      EV_PROMPT = 2'd0,
      EV_WORD   = 2'd1,
      EV_END    = 2'd2,
      EV_NOP    = 2'd3
   } ev_kind_t;

   typedef enum logic [1:0] {
      ST_OK  = 2'd0,
      ST_ERR = 2'd1,
      ST_TMO = 2'd2,
      ST_ERX = 2'd3
   } status_t;

   typedef enum logic [3:0] {
      S_IDLE, S_PROMPT, S_BRK, S_ADDR, S_SEP, S_SPC,
      S_DATA, S_PRE, S_MSP, S_MARK, S_TAIL
   } fmt_state_t;

   localparam logic [7:0] CH_CR = 8'h0D;
   localparam logic [7:0] CH_LF = 8'h0A;

   function automatic logic [7:0] nib2asc(input logic [3:0] n);
      return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
   endfunction

endpackage

// File: rtl/fmt_hex_digit.sv
module fmt_hex_digit #(
   parameter int W  = 16,
   parameter int IW = 3
) (
   input  logic [W-1:0]  value,
   input  logic [IW-1:0] idx,
   output logic [7:0]    char_o
);
   localparam int ND = (W + 3) / 4;
   localparam int PW = 4 * ND;

   logic [PW-1:0] padded;
   logic [3:0]    nib;

   assign padded = PW'(value);

   always_comb begin
      nib = 4'h0;
      for (int k = 0; k < ND; k++) begin
         if (idx == IW'(ND - 1 - k)) nib = padded[4*k +: 4];
      end
   end

   assign char_o = fmt_pkg::nib2asc(nib);
endmodule

// File: rtl/fmt_line_track.sv
module fmt_line_track #(
   parameter int WORDS_PER_LINE = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       word_acc,
   input  logic       end_acc,
   output logic       col_zero,
   output logic [1:0] wcnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)                        wcnt <= 2'd0;
      else if (end_acc)                  wcnt <= 2'd0;
      else if (word_acc && wcnt != 2'd2) wcnt <= wcnt + 2'd1;
   end

   generate
      if (WORDS_PER_LINE == 1) begin : g_single
         assign col_zero = 1'b1;
      end else begin : g_multi
         localparam int CW = $clog2(WORDS_PER_LINE);
         logic [CW-1:0] col;
         always_ff @(posedge clk) begin
            if (!rst_n)        col <= '0;
            else if (end_acc)  col <= '0;
            else if (word_acc) col <= (col == CW'(WORDS_PER_LINE - 1)) ? '0 : col + 1'b1;
         end
         assign col_zero = (col == '0);
      end
   endgenerate
endmodule

// File: rtl/hexdump_fmt.sv
module hexdump_fmt #(
   parameter int ADDR_W         = 16,
   parameter int DATA_W         = 16,
   parameter int WORDS_PER_LINE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   output logic              evt_ready,
   input  logic [1:0]        evt_kind,
   input  logic [1:0]        evt_status,
   input  logic [ADDR_W-1:0] evt_addr,
   input  logic [DATA_W-1:0] evt_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_char
);
   import fmt_pkg::*;

   localparam int AD   = (ADDR_W + 3) / 4;
   localparam int DD   = (DATA_W + 3) / 4;
   localparam int MAXN = (AD > DD) ? ((AD > 3) ? AD : 3) : ((DD > 3) ? DD : 3);
   localparam int IW   = $clog2(MAXN + 1);

   initial begin
      if (ADDR_W < 1 || DATA_W < 1) $error("hexdump_fmt: widths must be positive");
      if (WORDS_PER_LINE < 1)       $error("hexdump_fmt: WORDS_PER_LINE must be at least 1");
   end

   fmt_state_t        state;
   logic [IW-1:0]     idx;
   logic [ADDR_W-1:0] a_q;
   logic [DATA_W-1:0] d_q;
   status_t           st_q;
   logic              col_zero;
   logic [1:0]        wcnt;
   logic [7:0]        addr_ch, data_ch;
   logic              acc, fire, word_acc, end_acc;
   ev_kind_t          kind;
   logic [IW-1:0]     mark_last;

   assign kind      = ev_kind_t'(evt_kind);
   assign evt_ready = (state == S_IDLE);
   assign tx_valid  = (state != S_IDLE);
   assign acc       = evt_valid && evt_ready;
   assign fire      = tx_valid && tx_ready;
   assign word_acc  = acc && (kind == EV_WORD);
   assign end_acc   = acc && (kind == EV_END);
   assign mark_last = (st_q == ST_OK) ? IW'(1) : IW'(0);

   fmt_line_track #(.WORDS_PER_LINE(WORDS_PER_LINE)) u_track (
      .clk(clk), .rst_n(rst_n), .word_acc(word_acc), .end_acc(end_acc),
      .col_zero(col_zero), .wcnt(wcnt)
   );

   fmt_hex_digit #(.W(ADDR_W), .IW(IW)) u_addr_dig (.value(a_q), .idx(idx), .char_o(addr_ch));
   fmt_hex_digit #(.W(DATA_W), .IW(IW)) u_data_dig (.value(d_q), .idx(idx), .char_o(data_ch));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_IDLE;
         idx   <= '0;
         a_q   <= '0;
         d_q   <= '0;
         st_q  <= ST_OK;
      end else if (acc) begin
         idx <= '0;
         unique case (kind)
            EV_PROMPT: state <= S_PROMPT;
            EV_WORD: begin
               a_q <= evt_addr;
               d_q <= evt_data;
               if (!col_zero)          state <= S_SPC;
               else if (wcnt != 2'd0)  state <= S_BRK;
               else                    state <= S_ADDR;
            end
            EV_END: begin
               st_q <= status_t'(evt_status);
               if (wcnt == 2'd0)      state <= S_MARK;
               else if (wcnt == 2'd1) state <= S_MSP;
               else                   state <= S_PRE;
            end
            default: state <= S_IDLE;
         endcase
      end else if (fire) begin
         idx <= idx + 1'b1;
         unique case (state)
            S_PROMPT: if (idx == IW'(2))      begin state <= S_IDLE; idx <= '0; end
            S_BRK:    if (idx == IW'(1))      begin state <= S_ADDR; idx <= '0; end
            S_ADDR:   if (idx == IW'(AD - 1)) begin state <= S_SEP;  idx <= '0; end
            S_SEP:    if (idx == IW'(2))      begin state <= S_DATA; idx <= '0; end
            S_SPC:                            begin state <= S_DATA; idx <= '0; end
            S_DATA:   if (idx == IW'(DD - 1)) begin state <= S_IDLE; idx <= '0; end
            S_PRE:    if (idx == IW'(1))      begin state <= S_MARK; idx <= '0; end
            S_MSP:                            begin state <= S_MARK; idx <= '0; end
            S_MARK:   if (idx == mark_last)   begin state <= S_TAIL; idx <= '0; end
            S_TAIL:   if (idx == IW'(1))      begin state <= S_IDLE; idx <= '0; end
            default:                          begin state <= S_IDLE; idx <= '0; end
         endcase
      end
   end

   always_comb begin
      unique case (state)
         S_PROMPT: tx_char = (idx == '0) ? "-" : ((idx == IW'(1)) ? ">" : " ");
         S_BRK, S_PRE, S_TAIL: tx_char = (idx == '0) ? CH_CR : CH_LF;
         S_ADDR:   tx_char = addr_ch;
         S_SEP:    tx_char = (idx == IW'(1)) ? ":" : " ";
         S_SPC, S_MSP: tx_char = " ";
         S_DATA:   tx_char = data_ch;
         S_MARK: begin
            unique case (st_q)
               ST_OK:   tx_char = (idx == '0) ? "O" : "K";
               ST_TMO:  tx_char = "!";
               default: tx_char = "E";
            endcase
         end
         default:  tx_char = 8'h00;
      endcase
   end
endmodule

// File: rtl/hexdump_fmt_chk.sv
module hexdump_fmt_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       evt_ready,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_char
);
   // R10
   hold_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_char)));

   // R10
   busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_valid && evt_ready));

   // R5
   no_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !(tx_char >= 8'h61 && tx_char <= 8'h7A));

   // R11
   legal_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> ((tx_char >= 8'h20 && tx_char <= 8'h7E) || tx_char == 8'h0D || tx_char == 8'h0A));

   // R11
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (evt_ready && !tx_valid));
endmodule

bind hexdump_fmt hexdump_fmt_chk u_chk (
   .clk(clk), .rst_n(rst_n), .evt_ready(evt_ready),
   .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_char(tx_char)
);

// File: tb/hexdump_fmt_bench.sv
module hexdump_fmt_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic        evt_ready;
   logic [1:0]  evt_kind = 2'd0;
   logic [1:0]  evt_status = 2'd0;
   logic [15:0] evt_addr = '0;
   logic [15:0] evt_data = '0;
   logic        tx_valid;
   logic        tx_ready = 1'b1;
   logic [7:0]  tx_char;

   int errors = 0;
   int checks = 0;
   logic [7:0] cap [0:1023];
   int ncap = 0;
   int mark = 0;
   bit stall_en = 0;
   bit hold_low = 0;
   logic [7:0] lfsr = 8'h5A;
   int wd = 0;

   always #5 clk = ~clk;

   hexdump_fmt u_hexdump_fmt (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
      .evt_kind(evt_kind), .evt_status(evt_status), .evt_addr(evt_addr),
      .evt_data(evt_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_char(tx_char)
   );

   always @(posedge clk) begin
      if (rst_n && tx_valid && tx_ready && ncap < 1024) begin
         cap[ncap] <= tx_char;
         ncap <= ncap + 1;
      end
   end

   always @(negedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready <= hold_low ? 1'b0 : (stall_en ? lfsr[0] : 1'b1);
   end

   always @(posedge clk) begin
      wd <= wd + 1;
      if (wd == 100000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic string crlf();
      return $sformatf("%c%c", 8'd13, 8'd10);
   endfunction

   function automatic string hx(input logic [15:0] v);
      return $sformatf("%04X", v);
   endfunction

   function automatic string esc(input string s);
      string r = "";
      for (int i = 0; i < s.len(); i++) begin
         if (s[i] == 8'd13)      r = {r, "<CR>"};
         else if (s[i] == 8'd10) r = {r, "<LF>"};
         else                    r = $sformatf("%s%c", r, s[i]);
      end
      return r;
   endfunction

   task automatic check(input string req, input bit ok, input string act, input string exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%s expected=%s", req, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] k, input logic [1:0] st,
                       input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      evt_kind = k; evt_status = st; evt_addr = a; evt_data = d; evt_valid = 1'b1;
      while (!evt_ready) @(negedge clk);
      @(posedge clk);
      #1 evt_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!evt_ready) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic begin_capture();
      @(negedge clk);
      mark = ncap;
   endtask

   task automatic expect_text(input string req, input string exp);
      string got = "";
      wait_idle();
      for (int i = mark; i < ncap; i++) got = $sformatf("%s%c", got, cap[i]);
      check(req, got == exp, esc(got), esc(exp));
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R11 reset tx_valid", tx_valid == 1'b0, $sformatf("%b", tx_valid), "0");
      check("R11 reset evt_ready", evt_ready == 1'b1, $sformatf("%b", evt_ready), "1");
   endtask

   task automatic t_prompt();
      begin_capture();
      send(2'd0, 2'd0, 16'h0, 16'h0);
      expect_text("R1 prompt", "-> ");
   endtask

   task automatic t_write_ok();
      begin_capture();
      send(2'd2, 2'd0, 16'h0, 16'h0);
      expect_text("R6 no-word ok", {"OK", crlf()});
   endtask

   task automatic t_single();
      begin_capture();
      send(2'd1, 2'd0, 16'h0003, 16'h0048);
      send(2'd2, 2'd0, 16'h0, 16'h0);
      expect_text("R7 R2 single word", {"0003 : 0048 OK", crlf()});
   endtask

   task automatic t_line_full();
      string e;
      begin_capture();
      e = "0000 :";
      for (int i = 0; i < 8; i++) begin
         send(2'd1, 2'd0, 16'(i), 16'(16'h0100 + i));
         e = {e, " ", hx(16'(16'h0100 + i))};
      end
      send(2'd2, 2'd0, 16'h0, 16'h0);
      expect_text("R3 R8 eight words", {e, crlf(), "OK", crlf()});
   endtask

   task automatic t_wrap();
      string e;
      begin_capture();
      e = "0010 :";
      for (int i = 0; i < 10; i++) begin
         send(2'd1, 2'd0, 16'(16'h0010 + i), 16'(i));
         if (i == 8) e = {e, crlf(), hx(16'(16'h0010 + i)), " :"};
         e = {e, " ", hx(16'(i))};
      end
      send(2'd2, 2'd0, 16'h0, 16'h0);
      expect_text("R4 line wrap", {e, crlf(), "OK", crlf()});
   endtask

   task automatic t_short_multi();
      begin_capture();
      send(2'd1, 2'd0, 16'h0200, 16'h0001);
      send(2'd1, 2'd0, 16'h0201, 16'h0002);
      send(2'd1, 2'd0, 16'h0202, 16'h0003);
      send(2'd2, 2'd0, 16'h0, 16'h0);
      expect_text("R8 three words", {"0200 : 0001 0002 0003", crlf(), "OK", crlf()});
   endtask

   task automatic t_pad_upper();
      stall_en = 1;
      begin_capture();
      send(2'd1, 2'd0, 16'h00AB, 16'hBEEF);
      send(2'd1, 2'd0, 16'h00AC, 16'h000C);
      send(2'd2, 2'd0, 16'h0, 16'h0);
      expect_text("R5 padding uppercase", {"00AB : BEEF 000C", crlf(), "OK", crlf()});
      stall_en = 0;
   endtask

   task automatic t_error();
      begin_capture();
      send(2'd1, 2'd0, 16'h0005, 16'h1234);
      send(2'd2, 2'd1, 16'h0, 16'h0);
      expect_text("R9 error marker", {"0005 : 1234 E", crlf()});
      begin_capture();
      send(2'd2, 2'd3, 16'h0, 16'h0);
      expect_text("R9 status3 error", {"E", crlf()});
   endtask

   task automatic t_timeout();
      begin_capture();
      send(2'd2, 2'd2, 16'h0, 16'h0);
      expect_text("R9 timeout marker", {"!", crlf()});
      begin_capture();
      send(2'd1, 2'd0, 16'hFFFF, 16'hA5A5);
      send(2'd1, 2'd0, 16'h0000, 16'h5A5A);
      send(2'd2, 2'd2, 16'h0, 16'h0);
      expect_text("R9 timeout after words", {"FFFF : A5A5 5A5A", crlf(), "!", crlf()});
   endtask

   task automatic t_nop();
      begin_capture();
      send(2'd1, 2'd0, 16'h0030, 16'h0031);
      send(2'd3, 2'd0, 16'h0, 16'h0);
      send(2'd1, 2'd0, 16'h0032, 16'h0033);
      send(2'd2, 2'd0, 16'h0, 16'h0);
      expect_text("R12 no-op ignored", {"0030 : 0031 0033", crlf(), "OK", crlf()});
   endtask

   task automatic t_stall();
      bit ok = 1;
      begin_capture();
      hold_low = 1;
      send(2'd0, 2'd0, 16'h0, 16'h0);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (!(tx_valid && tx_char == "-" && !evt_ready)) ok = 0;
      end
      check("R10 hold under stall", ok, $sformatf("v=%b c=%02h r=%b", tx_valid, tx_char, evt_ready), "v=1 c=2d r=0");
      hold_low = 0;
      expect_text("R10 no loss after stall", "-> ");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_prompt();
      t_write_ok();
      t_single();
      t_line_full();
      t_wrap();
      t_single();
      t_short_multi();
      t_pad_upper();
      t_error();
      t_timeout();
      t_nop();
      t_stall();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule